// File: doc/BRIEF.md
# Triggered Serial Pattern Playback Sequencer

The block plays a stored bit pattern as two serial bit streams, a "set" stream and a "clear" stream. The two patterns sit in two word-organised memories that share one address and one read strobe. A bit pointer moves forward one position per clock. It returns to position zero after a programmable last position. A trigger pulse can also load it with a programmable start position.

A 2-bit mode input picks one of three behaviours. The block can stay idle. It can loop forever. It can wait for a trigger and then make one single pass up to the last position, after which it stops while the mode input still asks for single-pass operation.

The upper pointer bits address a 32-bit memory word, and the lower five bits choose the bit inside that word. A new word is fetched only when the pointer enters a different word. A held copy of the current word keeps the stream free of gaps across word boundaries. Everything runs on one clock with a synchronous active-high reset.

Top module: `pattern_player`

## Requirements
- R1: Mode encoding: `01` is loop, `10` is single-pass, and `00` and `11` are both idle. While idle, `running_o`, `set_bit_o`, `clr_bit_o` and `pat_rd_o` are all 0.
- R2: At the first clock edge that samples an idle mode, `running_o`, `set_bit_o` and `clr_bit_o` all go to 0, and they stay 0 while the mode stays idle.
- R3: In loop mode the pointer holds position 0 in the first cycle after the mode is sampled. It then advances by one each clock. After holding `wrap_pos_i` it holds 0 again, so the period is `wrap_pos_i`+1 cycles.
- R4: In loop mode, when a trigger is sampled the pointer holds `trig_pos_i` in the next cycle. This takes priority over the return to 0 at `wrap_pos_i`.
- R5: In single-pass mode the block stays idle until a trigger arrives. The trigger loads `trig_pos_i`, and the pointer advances up to and including `wrap_pos_i`. After that, `running_o` drops and the outputs return to 0. A later trigger starts a new pass.
- R6: In single-pass mode, a trigger that arrives while a pass is running has no effect on the pointer sequence.
- R7: For pointer position p, the set output carries bit p[4:0] of set-memory word p[15:5], and the clear output carries the same bit of the clear-memory word. The bit appears on the outputs after the second clock edge following the cycle in which the pointer holds p.
- R8: `pat_rd_o` is high, with `pat_addr_o` = p[15:5], in exactly those active cycles whose word differs from the word last fetched during the current run. The first active cycle of a run always fetches. Both memories return the word in the following cycle. The strobe is never high while idle.
- R9: `running_o` is high exactly in the cycles in which the pointer holds a position that is being played.
- R10: While reset is asserted, `running_o`, `pat_rd_o`, `set_bit_o` and `clr_bit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Operating mode (00 idle, 01 loop, 10 single-pass, 11 idle) |
| wrap_pos_i | input | 16 | Last position played before returning to 0 |
| trig_pos_i | input | 16 | Position loaded by a trigger |
| trig_i | input | 1 | Trigger pulse, sampled on the clock |
| pat_addr_o | output | 11 | Word address for both pattern memories |
| pat_rd_o | output | 1 | Read strobe for both pattern memories |
| set_data_i | input | 32 | Set-pattern word, valid the cycle after the strobe |
| clr_data_i | input | 32 | Clear-pattern word, valid the cycle after the strobe |
| set_bit_o | output | 1 | Serial set stream |
| clr_bit_o | output | 1 | Serial clear stream |
| running_o | output | 1 | Pattern playback active |

## Verification
The hardest cases to reach from the ports are those where a trigger lands in one exact cycle: a loop-mode trigger in the very cycle the pointer sits on its last position, and a single-pass trigger in the middle of a pass. The bench keeps its own position count from the requirements and raises the trigger only when that count reaches the chosen position. The loop-mode last position is swept across word boundaries: a single word, exactly one word, one past a word, and several words. This exercises refetch after the wrap, and the bench counts read strobes over one full period.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int NUM_LANES = 2;

    typedef enum logic [1:0] {
        PM_IDLE   = 2'd0,
        PM_LOOP   = 2'd1,
        PM_SINGLE = 2'd2
    } run_kind_e;

    // flags carried from the pointer stage to the bit-select stage
    typedef struct packed {
        logic live;
        logic fresh;
    } tap_flags_t;

    function automatic run_kind_e decode_mode(input logic [1:0] m);
        run_kind_e k;
        case (m)
            2'b01:   k = PM_LOOP;
            2'b10:   k = PM_SINGLE;
            default: k = PM_IDLE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/pp_pointer.sv
module pp_pointer
    import pp_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  run_kind_e        kind_i,
    input  logic [PTR_W-1:0] wrap_pos_i,
    input  logic [PTR_W-1:0] trig_pos_i,
    input  logic             trig_i,
    output logic             act_o,
    output logic [PTR_W-1:0] pos_o
);

    typedef struct packed {
        logic             act;
        logic [PTR_W-1:0] pos;
    } walk_t;

    walk_t cur_q, nxt;
    logic  at_wrap;

    assign at_wrap = (cur_q.pos == wrap_pos_i);

    always_comb begin
        nxt = cur_q;
        case (kind_i)
            PM_LOOP: begin
                nxt.act = 1'b1;
                if (trig_i)
                    nxt.pos = trig_pos_i;
                else if (!cur_q.act || at_wrap)
                    nxt.pos = '0;
                else
                    nxt.pos = cur_q.pos + 1'b1;
            end
            PM_SINGLE: begin
                if (cur_q.act) begin
                    if (at_wrap) begin
                        nxt.act = 1'b0;
                        nxt.pos = '0;
                    end else begin
                        nxt.pos = cur_q.pos + 1'b1;
                    end
                end else if (trig_i) begin
                    nxt.act = 1'b1;
                    nxt.pos = trig_pos_i;
                end
            end
            default: begin
                nxt.act = 1'b0;
                nxt.pos = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end

    assign act_o = cur_q.act;
    assign pos_o = cur_q.pos;

    // R2
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == PM_IDLE) |=> !act_o);

    // R3
    loop_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == PM_LOOP && act_o && at_wrap && !trig_i) |=> (pos_o == '0));

    // R4
    loop_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == PM_LOOP && trig_i) |=> (act_o && pos_o == $past(trig_pos_i)));

    // R5
    single_end_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == PM_SINGLE && act_o && at_wrap) |=> !act_o);

    // R6
    single_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == PM_SINGLE && act_o && !at_wrap && trig_i)
        |=> (act_o && pos_o == $past(pos_o) + 1'b1));

endmodule

// File: rtl/pp_fetch.sv
module pp_fetch #(
    parameter int PTR_W  = 16,
    parameter int SEL_W  = 5,
    localparam int ADDR_W = PTR_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_i,
    input  logic [PTR_W-1:0]  pos_i,
    output logic              rd_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic              held_v_q;
    logic [ADDR_W-1:0] held_idx_q;
    logic [ADDR_W-1:0] word_idx;

    assign word_idx = pos_i[PTR_W-1:SEL_W];
    assign addr_o   = word_idx;
    assign rd_o     = act_i && (!held_v_q || (word_idx != held_idx_q));

    always_ff @(posedge clk) begin
        if (rst || !act_i) begin
            held_v_q   <= 1'b0;
            held_idx_q <= '0;
        end else if (rd_o) begin
            held_v_q   <= 1'b1;
            held_idx_q <= word_idx;
        end
    end

    // R8
    no_refetch_chk: assert property (@(posedge clk) disable iff (rst)
        rd_o |=> (!rd_o || addr_o != $past(addr_o)));

endmodule

// File: rtl/pp_lane.sv
module pp_lane #(
    parameter int WORD_W = 32,
    localparam int SEL_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              live_i,
    input  logic              fresh_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              halt_i,
    input  logic [WORD_W-1:0] data_i,
    output logic              bit_o
);

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] src;

    assign src = fresh_i ? data_i : word_q;

    always_ff @(posedge clk) begin
        if (rst)          word_q <= '0;
        else if (fresh_i) word_q <= data_i;
    end

    always_ff @(posedge clk) begin
        if (rst || halt_i) bit_o <= 1'b0;
        else               bit_o <= live_i & src[sel_i];
    end

    // R2
    halt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        halt_i |=> !bit_o);

endmodule

// File: rtl/pattern_player.sv
module pattern_player
    import pp_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int WORD_W = 32,
    localparam int SEL_W  = $clog2(WORD_W),
    localparam int ADDR_W = PTR_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic [PTR_W-1:0]  wrap_pos_i,
    input  logic [PTR_W-1:0]  trig_pos_i,
    input  logic              trig_i,
    output logic [ADDR_W-1:0] pat_addr_o,
    output logic              pat_rd_o,
    input  logic [WORD_W-1:0] set_data_i,
    input  logic [WORD_W-1:0] clr_data_i,
    output logic              set_bit_o,
    output logic              clr_bit_o,
    output logic              running_o
);

    run_kind_e        kind;
    logic             act;
    logic [PTR_W-1:0] pos;
    tap_flags_t       tap_q;
    logic [SEL_W-1:0] sel_q;
    logic             halt;

    logic [NUM_LANES-1:0][WORD_W-1:0] lane_data;
    logic [NUM_LANES-1:0]             lane_bit;

    assign kind = decode_mode(mode_i);
    assign halt = (kind == PM_IDLE);

    pp_pointer #(.PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .kind_i     (kind),
        .wrap_pos_i (wrap_pos_i),
        .trig_pos_i (trig_pos_i),
        .trig_i     (trig_i),
        .act_o      (act),
        .pos_o      (pos)
    );

    pp_fetch #(.PTR_W(PTR_W), .SEL_W(SEL_W)) u_fetch (
        .clk    (clk),
        .rst    (rst),
        .act_i  (act),
        .pos_i  (pos),
        .rd_o   (pat_rd_o),
        .addr_o (pat_addr_o)
    );

    // align stage: which bit to pick once the word is present
    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q <= '0;
            sel_q <= '0;
        end else begin
            tap_q.live  <= act;
            tap_q.fresh <= pat_rd_o;
            sel_q       <= pos[SEL_W-1:0];
        end
    end

    assign lane_data[0] = set_data_i;
    assign lane_data[1] = clr_data_i;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        pp_lane #(.WORD_W(WORD_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .live_i  (tap_q.live),
            .fresh_i (tap_q.fresh),
            .sel_i   (sel_q),
            .halt_i  (halt),
            .data_i  (lane_data[g]),
            .bit_o   (lane_bit[g])
        );
    end

    assign set_bit_o = lane_bit[0];
    assign clr_bit_o = lane_bit[1];
    assign running_o = act;

    // R1
    idle_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> !pat_rd_o);

    // R9
    start_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!running_o && kind == PM_LOOP) |=> (running_o && pat_rd_o));

endmodule

// File: tb/sim_pattern_player.sv
`timescale 1ns/1ps
module sim_pattern_player;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic [15:0] wrap;
    logic [15:0] lat;
    logic        trig;
    logic [10:0] pat_addr;
    logic        pat_rd;
    logic [31:0] set_q, clr_q;
    logic        set_bit, clr_bit, running;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench-side expected state
    bit ev, s1v, hv, prd;
    int ep, s1p, hw;
    int rd_cnt;

    always #10 clk = ~clk;

    pattern_player u0 (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .wrap_pos_i (wrap),
        .trig_pos_i (lat),
        .trig_i     (trig),
        .pat_addr_o (pat_addr),
        .pat_rd_o   (pat_rd),
        .set_data_i (set_q),
        .clr_data_i (clr_q),
        .set_bit_o  (set_bit),
        .clr_bit_o  (clr_bit),
        .running_o  (running)
    );

    function automatic logic [31:0] set_word(input int a);
        return 32'(a * 32'h9E3779B1) ^ 32'h0F1E2D3C;
    endfunction

    function automatic logic [31:0] clr_word(input int a);
        return ~32'(a * 32'h85EBCA6B) ^ 32'hA5A50F0F;
    endfunction

    function automatic bit pat_bit(input bit which, input int p);
        logic [31:0] w;
        w = which ? clr_word(p >> 5) : set_word(p >> 5);
        return w[p & 31];
    endfunction

    // one-cycle synchronous pattern memories
    always @(posedge clk) begin
        if (pat_rd) begin
            set_q <= set_word(int'(pat_addr));
            clr_q <= clr_word(int'(pat_addr));
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act_v, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act_v, exp_v);
        end
    endtask

    // advance one clock and compare every output with the requirement model
    task automatic step(input string tag);
        bit nv, halt_now, es, ec, erd;
        int np;
        halt_now = !(mode == 2'b01 || mode == 2'b10);
        nv = ev; np = ep;
        if (mode == 2'b01) begin
            nv = 1;
            if (trig) np = int'(lat);
            else if (!ev || ep == int'(wrap)) np = 0;
            else np = ep + 1;
        end else if (mode == 2'b10) begin
            if (ev) begin
                if (ep == int'(wrap)) begin nv = 0; np = 0; end
                else np = ep + 1;
            end else if (trig) begin
                nv = 1; np = int'(lat);
            end
        end else begin
            nv = 0; np = 0;
        end
        es = !halt_now && s1v && pat_bit(0, s1p);
        ec = !halt_now && s1v && pat_bit(1, s1p);
        if (!ev) hv = 0;
        else if (prd) begin hv = 1; hw = ep >> 5; end
        s1v = ev; s1p = ep; ev = nv; ep = np;
        erd = ev && (!hv || (ep >> 5) != hw);
        prd = erd;
        @(posedge clk);
        @(negedge clk);
        chk(running == ev, tag, "R9 running", int'(running), int'(ev));
        chk(set_bit == es, tag, "R7 set bit", int'(set_bit), int'(es));
        chk(clr_bit == ec, tag, "R7 clear bit", int'(clr_bit), int'(ec));
        chk(pat_rd == erd, tag, "R8 strobe", int'(pat_rd), int'(erd));
        if (erd) chk(int'(pat_addr) == (ep >> 5), tag, "R8 address", int'(pat_addr), ep >> 5);
        if (pat_rd) rd_cnt++;
    endtask

    task automatic go_idle(input int cycles);
        mode = 2'b00; trig = 0;
        for (int i = 0; i < cycles; i++) step("R2");
    endtask

    initial begin
        int wraps[10];
        int lats[6];
        int words, exp_cnt;
        wraps = '{0, 1, 5, 31, 32, 33, 63, 64, 95, 100};
        lats  = '{0, 1, 7, 31, 32, 44};
        rst = 1; mode = 2'b00; wrap = 16'd0; lat = 16'd0; trig = 0;
        ev = 0; ep = 0; s1v = 0; s1p = 0; hv = 0; hw = 0; prd = 0; rd_cnt = 0;
        repeat (3) @(negedge clk);
        // R10 reset state, with a loop mode pending
        mode = 2'b01; trig = 1;
        @(negedge clk);
        chk(running == 0, "R10", "running in reset", int'(running), 0);
        chk(pat_rd == 0, "R10", "strobe in reset", int'(pat_rd), 0);
        chk(set_bit == 0 && clr_bit == 0, "R10", "bits in reset",
            int'({set_bit, clr_bit}), 0);
        mode = 2'b00; trig = 0;
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < 4; i++) step("R1");
        // R1 code 11 behaves as idle, trigger included
        mode = 2'b11; trig = 1;
        for (int i = 0; i < 6; i++) step("R1");
        trig = 0;

        // R3 loop sweep over last positions around word edges
        foreach (wraps[k]) begin
            go_idle(3);
            wrap = 16'(wraps[k]); lat = 16'd0; mode = 2'b01;
            for (int i = 0; i < wraps[k] + 6; i++) step("R3");
            rd_cnt = 0;
            for (int i = 0; i <= wraps[k]; i++) step("R3");
            words = wraps[k] / 32 + 1;
            exp_cnt = (words > 1) ? words : 0;
            chk(rd_cnt == exp_cnt, "R8", "strobes per period", rd_cnt, exp_cnt);
        end
        go_idle(4);

        // R4 triggers in loop mode, one at the last position
        wrap = 16'd70; lat = 16'd9; mode = 2'b01;
        for (int i = 0; i < 20; i++) step("R4");
        trig = 1; step("R4"); trig = 0;
        for (int i = 0; i < 5; i++) step("R4");
        while (ep != int'(wrap)) step("R4");
        trig = 1; step("R4"); trig = 0;
        chk(ep == 9 && running, "R4", "trigger beats wrap", int'(running), 1);
        for (int i = 0; i < 40; i++) step("R4");
        lat = 16'd33;
        trig = 1; step("R4"); trig = 0;
        for (int i = 0; i < 50; i++) step("R4");
        go_idle(4);

        // R5 / R6 single-pass over several start positions
        wrap = 16'd45; mode = 2'b10;
        foreach (lats[k]) begin
            lat = 16'(lats[k]);
            for (int i = 0; i < 4; i++) step("R5");
            chk(running == 0, "R5", "waits for trigger", int'(running), 0);
            trig = 1; step("R5"); trig = 0;
            if (ev) step("R6");
            if (ev) begin trig = 1; step("R6"); trig = 0; end
            while (ev) step("R6");
            for (int i = 0; i < 4; i++) step("R5");
            chk(running == 0 && set_bit == 0 && clr_bit == 0, "R5",
                "stopped after pass", int'({running, set_bit, clr_bit}), 0);
        end
        // R2 stop in the middle of a loop
        mode = 2'b01; wrap = 16'd90;
        for (int i = 0; i < 30; i++) step("R3");
        go_idle(5);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule